// File: doc/BRIEF.md
# Multiphase Time-Gated Photon Counter Array

This block collects photon detections from a line of single-photon pixels arranged as independent columns across spectral rows. A laser trigger arms the array just ahead of each pulse, and a gate-phase timing strobe then steps through a fixed number of short consecutive gate windows. Each pixel keeps its own saturating count for every window, so photons that arrive promptly, such as scattered light, can be told apart from photons that arrive late, such as fluorescence. For each shot, every pixel also records a small arrival code that names the window of its first detection.

A registered readout port returns one pixel's count for a chosen window, that pixel's arrival code, and the sum for the addressed spectral row and window across all columns. A per-pixel exclusion mask removes noisy pixels from that row sum. A clear command zeroes all counters and codes between spectra.

Top module: `gated_photon_counter`

## Requirements
- R1: After reset every count and arrival code reads zero and the gate sequencer is closed, so hits and gate strobes have no effect until the first trigger.
- R2: A trigger opens window 0 from the next cycle. Hits in the trigger cycle are not counted. A trigger that arrives during an open sequence restarts it at window 0.
- R3: Each gate strobe during an open sequence moves to the next window. A hit counts toward the window that is open in its own cycle, including the strobe cycle. The strobe that ends the last window (index NGATE-1) closes the sequence, and hits received while the sequence is closed are ignored.
- R4: Each pixel adds at most one count per window per shot. Further hits from that pixel in the same window are ignored.
- R5: Each counter stops at 2^CW-1 and never wraps. It changes by at most one per cycle.
- R6: A pixel's arrival code is 0 when the pixel has had no counted hit since the last trigger. Otherwise it is 1 plus the index of the window of its first counted hit. A trigger clears all codes.
- R7: The pixel at row r and column c has index r*NCOL+c, and that index selects its bit of `mask`. The row sum for (r, g) is the sum of the window-g counts of the columns in row r whose mask bit is 0.
- R8: A clear zeroes all counters and codes. Hits in the clear cycle are not counted. The gate sequencer is not affected, and a later hit in the same window still counts.
- R9: The readout outputs are registered. They show the counts, code and sum that were present at the clock edge that sampled the read address.
- R10: Pixels do not interact. A hit on one pixel changes only that pixel's counter and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| laser_trig | input | 1 | Shot start; arms window 0 |
| gate_tick | input | 1 | Gate-phase strobe; advances to the next window |
| clear | input | 1 | Zeroes all counters and codes |
| hit | input | NCOL*NROW | One-cycle detection pulse per pixel |
| mask | input | NCOL*NROW | 1 excludes a pixel from the row sum |
| rd_row | input | $clog2(NROW) | Readout row |
| rd_col | input | $clog2(NCOL) | Readout column |
| rd_gate | input | $clog2(NGATE) | Readout window |
| rd_count | output | CW | Count of the addressed pixel and window |
| rd_code | output | $clog2(NGATE+1) | Arrival code of the addressed pixel |
| rd_sum | output | CW+$clog2(NCOL) | Masked row sum for the addressed row and window |

## Verification
The bench builds the block with four columns, two rows, four windows and 3-bit counters. This gives eight pixels and 32 counters, so a full readout sweep after every shot compares every count, every arrival code and every masked row sum against the bench's model. With a counter ceiling of seven, a handful of shots is enough to drive counters into saturation. The shot patterns vary the hit pattern, repeated hits within a window, hits on the strobe cycle, hits on the trigger cycle, hits after the sequence closes, a clear in the middle of a window, a retrigger in the middle of a sequence, and the mask value.

// File: rtl/gated_photon_counter.sv
module gated_photon_counter #(
  parameter int NCOL  = 4,
  parameter int NROW  = 128,
  parameter int NGATE = 4,
  parameter int CW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          laser_trig,
  input  logic                          gate_tick,
  input  logic                          clear,
  input  logic [NCOL*NROW-1:0]          hit,
  input  logic [NCOL*NROW-1:0]          mask,
  input  logic [$clog2(NROW)-1:0]       rd_row,
  input  logic [$clog2(NCOL)-1:0]       rd_col,
  input  logic [$clog2(NGATE)-1:0]      rd_gate,
  output logic [CW-1:0]                 rd_count,
  output logic [$clog2(NGATE+1)-1:0]    rd_code,
  output logic [CW+$clog2(NCOL)-1:0]    rd_sum
);
  localparam int NPIX = NCOL * NROW;
  localparam int GW   = $clog2(NGATE);
  localparam int KW   = $clog2(NGATE + 1);
  localparam int SW   = CW + $clog2(NCOL);
  localparam logic [CW-1:0] MAXC = '1;

  logic                active;
  logic [GW-1:0]       gidx;
  logic [NPIX-1:0]     seen;
  logic [NPIX-1:0]     count_en;
  logic [CW-1:0]       cnt  [NPIX*NGATE];
  logic [KW-1:0]       code [NPIX];
  logic [NPIX*NGATE*CW-1:0] cnt_flat;
  logic [NPIX*KW-1:0]  code_flat;
  logic [SW-1:0]       sum_c;

  wire advance = laser_trig | (gate_tick & active);
  assign count_en = hit & ~seen & {NPIX{active & ~clear & ~laser_trig}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      gidx   <= '0;
    end else if (laser_trig) begin
      active <= 1'b1;
      gidx   <= '0;
    end else if (gate_tick && active) begin
      if (gidx == GW'(NGATE - 1)) active <= 1'b0;
      else                        gidx   <= gidx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen <= '0;
    else if (clear | advance) seen <= '0;
    else                      seen <= seen | (hit & {NPIX{active}});
  end

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    for (genvar g = 0; g < NGATE; g++) begin : g_gate
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt[p*NGATE+g] <= '0;
        else if (clear)
          cnt[p*NGATE+g] <= '0;
        else if (count_en[p] && gidx == GW'(g) && cnt[p*NGATE+g] != MAXC)
          cnt[p*NGATE+g] <= cnt[p*NGATE+g] + 1'b1;
      end
      assign cnt_flat[(p*NGATE+g)*CW +: CW] = cnt[p*NGATE+g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      code[p] <= '0;
      else if (clear || laser_trig)    code[p] <= '0;
      else if (count_en[p] && code[p] == '0)
        code[p] <= KW'(gidx) + KW'(1);
    end
    assign code_flat[p*KW +: KW] = code[p];
  end

  always_comb begin
    sum_c = '0;
    for (int c = 0; c < NCOL; c++) begin
      if (!mask[int'(rd_row)*NCOL + c])
        sum_c = sum_c + SW'(cnt[(int'(rd_row)*NCOL + c)*NGATE + int'(rd_gate)]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_count <= '0;
      rd_code  <= '0;
      rd_sum   <= '0;
    end else begin
      rd_count <= cnt[(int'(rd_row)*NCOL + int'(rd_col))*NGATE + int'(rd_gate)];
      rd_code  <= code[int'(rd_row)*NCOL + int'(rd_col)];
      rd_sum   <= sum_c;
    end
  end
endmodule

// File: rtl/gated_photon_counter_chk.sv
module gated_photon_counter_chk #(
  parameter int NPIX  = 8,
  parameter int NGATE = 4,
  parameter int CW    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          laser_trig,
  input logic                          gate_tick,
  input logic                          clear,
  input logic                          active,
  input logic [$clog2(NGATE)-1:0]      gidx,
  input logic [NPIX*NGATE*CW-1:0]      cnt_flat,
  input logic [NPIX*$clog2(NGATE+1)-1:0] code_flat
);
  assert_trig_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    laser_trig |=> (active && gidx == '0));

  assert_last_tick_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gate_tick && !laser_trig && gidx == ($clog2(NGATE))'(NGATE - 1)) |=> !active);

  assert_closed_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(cnt_flat));

  assert_code_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (laser_trig || clear) |=> code_flat == '0);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_flat == '0);

  for (genvar k = 0; k < NPIX*NGATE; k++) begin : g_step
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (cnt_flat[k*CW +: CW] == $past(cnt_flat[k*CW +: CW]) ||
                  32'(cnt_flat[k*CW +: CW]) == 32'($past(cnt_flat[k*CW +: CW])) + 1));
  end
endmodule

bind gated_photon_counter gated_photon_counter_chk #(
  .NPIX(NCOL*NROW), .NGATE(NGATE), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .laser_trig(laser_trig), .gate_tick(gate_tick),
  .clear(clear), .active(active), .gidx(gidx),
  .cnt_flat(cnt_flat), .code_flat(code_flat)
);

// File: tb/gated_photon_counter_tb_top.sv
`timescale 1ns/1ps
module gated_photon_counter_tb_top;
  localparam int NCOL = 4, NROW = 2, NGATE = 4, CW = 3;
  localparam int NPIX = NCOL * NROW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, laser_trig = 0, gate_tick = 0, clear = 0;
  logic [NPIX-1:0] hit = '0, mask = '0;
  logic [0:0] rd_row = '0;
  logic [1:0] rd_col = '0, rd_gate = '0;
  logic [CW-1:0] rd_count;
  logic [2:0] rd_code;
  logic [CW+1:0] rd_sum;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_cnt [NPIX][NGATE];
  int exp_code [NPIX];

  always #2.5 clk = ~clk;

  gated_photon_counter #(.NCOL(NCOL), .NROW(NROW), .NGATE(NGATE), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .laser_trig(laser_trig), .gate_tick(gate_tick),
    .clear(clear), .hit(hit), .mask(mask), .rd_row(rd_row), .rd_col(rd_col),
    .rd_gate(rd_gate), .rd_count(rd_count), .rd_code(rd_code), .rd_sum(rd_sum));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic k, input logic c, input logic [NPIX-1:0] h);
    @(negedge clk);
    laser_trig = t; gate_tick = k; clear = c; hit = h;
  endtask

  task automatic model_hits(input int g, input logic [NPIX-1:0] h);
    for (int p = 0; p < NPIX; p++)
      if (h[p]) begin
        if (exp_cnt[p][g] < MAXC) exp_cnt[p][g]++;
        if (exp_code[p] == 0) exp_code[p] = g + 1;
      end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NPIX; p++) begin
      exp_code[p] = 0;
      for (int g = 0; g < NGATE; g++) exp_cnt[p][g] = 0;
    end
  endtask

  task automatic trig_model(input logic [NPIX-1:0] h);
    cyc(1, 0, 0, h);  // R2: hits in trigger cycle ignored
    for (int p = 0; p < NPIX; p++) exp_code[p] = 0;
  endtask

  task automatic shot(input logic [NGATE-1:0][NPIX-1:0] w, input bit dup, input bit late);
    trig_model('1);
    for (int g = 0; g < NGATE; g++) begin
      if (late) cyc(0, 1, 0, w[g]);          // R3: hit on strobe cycle
      else begin
        cyc(0, 0, 0, w[g]);
        if (dup) cyc(0, 0, 0, w[g]);         // R4: repeat ignored
        cyc(0, 1, 0, '0);
      end
      model_hits(g, w[g]);
    end
    cyc(0, 0, 0, '1);                         // R3: closed, ignored
    cyc(0, 1, 0, '1);
    cyc(0, 0, 0, '0);
  endtask

  task automatic readall(input logic [NPIX-1:0] m);
    @(negedge clk);
    mask = m; hit = '0; laser_trig = 0; gate_tick = 0; clear = 0;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        for (int g = 0; g < NGATE; g++) begin
          int s;
          rd_row = 1'(r); rd_col = 2'(c); rd_gate = 2'(g);
          @(negedge clk);  // R9: one registered cycle
          s = 0;
          for (int cc = 0; cc < NCOL; cc++)
            if (!m[r*NCOL+cc]) s += exp_cnt[r*NCOL+cc][g];
          chk("R4/R5/R10 count", int'(rd_count), exp_cnt[r*NCOL+c][g]);
          chk("R6 code", int'(rd_code), exp_code[r*NCOL+c]);
          chk("R7 sum", int'(rd_sum), s);
        end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NGATE-1:0][NPIX-1:0] w;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, stimulus ignored
    cyc(0, 1, 0, '1);
    cyc(0, 0, 0, '1);
    cyc(0, 1, 0, '1);
    readall('0);

    for (int s = 0; s < 10; s++) begin
      for (int g = 0; g < NGATE; g++)
        w[g] = NPIX'((s*29 + g*71 + 13) ^ (s << g));
      shot(w, s[0], s[1]);
      readall(NPIX'(s*53 + 7));
    end

    // R5: saturate everything
    for (int s = 0; s < MAXC + 1; s++) begin
      for (int g = 0; g < NGATE; g++) w[g] = '1;
      shot(w, 1'b0, 1'b0);
    end
    readall(8'h5A);

    // R8: clear inside window 0 with hits, then a hit in the same window
    trig_model('0);
    cyc(0, 0, 1, '1);
    model_clear();
    cyc(0, 0, 0, 8'hA5);
    model_hits(0, 8'hA5);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 0, 8'h0F);
    model_hits(1, 8'h0F);
    cyc(0, 1, 0, '0);
    cyc(0, 1, 0, '0);
    cyc(0, 1, 0, '0);
    cyc(0, 0, 0, '1);
    cyc(0, 0, 0, '0);
    readall('0);

    // R2: retrigger mid-sequence restarts at window 0 and clears codes
    trig_model('0);
    cyc(0, 1, 0, 8'h33);
    model_hits(0, 8'h33);
    cyc(0, 0, 0, 8'hC0);
    model_hits(1, 8'hC0);
    trig_model(8'hFF);
    cyc(0, 0, 0, 8'h18);
    model_hits(0, 8'h18);
    cyc(0, 0, 0, '0);
    readall(8'h81);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule